// File: doc/BRIEF.md
# Shared Time Base and Watchdog Interrupt Generator

This block derives a slow periodic square wave and a watchdog time-out from one shared binary divider. The divider runs from a 32 kHz base tick. That tick is produced by an internal divide-by-eight prescaler when the system clock is the 256 kHz source. When the clock already runs at 32 kHz, a bypass input skips the prescaler. A 3-bit rate select sets the output rate to 2^n of the slowest rate. At the default depth the rates run from 1 Hz (select 0) to 128 Hz (select 7). A two-stage watchdog counter counts completed periods of the selected square wave. On the fourth completed period it raises a sticky time-out flag.

Single-cycle command strobes, which an outside decoder supplies, drive a three-state routing machine. **HALT** is the reset state: the divider is frozen and nothing is routed. **TBASE** runs the divider and routes the square wave to the interrupt line. **WDOG** runs the divider and routes the inverted time-out flag to the interrupt line. The transitions are:

- Watchdog disable goes from any state to HALT.
- Watchdog enable goes from any state to WDOG.
- Timer disable goes from TBASE to HALT.
- Timer enable goes from HALT or WDOG to TBASE.

A separate enable register decides whether the interrupt line is driven at all. The line behaves as an open-drain pin: `irq_oe` high means the pin is driven, and `irq_lvl` is the level on it.

Top module: `tbwd_irq`

## Requirements
- R1: After reset `irq_oe` is 0, `irq_lvl` is 1, the routing state is HALT and the divider holds at zero.
- R2: An IRQ enable strobe sets `irq_oe` from the next cycle. An IRQ disable strobe clears it from the next cycle and also clears the time-out flag. When both strobes arrive in the same cycle, disable wins.
- R3: In TBASE, `irq_lvl` equals divider bit (TB_STAGES-1-n), where n is `rate_sel`. After a clear the divider starts at zero, so the wave gives 2^(TB_STAGES-1-n) base ticks low, then the same number high.
- R4: With `presc_bypass`=0, one base tick occurs every 2^PRE_LOG2 clocks. With `presc_bypass`=1, every clock with `sys_en` high is a base tick.
- R5: In WDOG the flag sets on the fourth high-to-low transition of the selected divider bit. `irq_lvl` is then 0 and stays 0 until a clear-watchdog or IRQ-disable strobe arrives.
- R6: Clear-watchdog zeroes the divider, the prescaler, the watchdog stages and the flag. Clear-timer zeroes only the divider and the prescaler, so the flag is kept. A clear beats a count in the same cycle.
- R7: In HALT the divider holds its value and `irq_lvl` is 1. A later enable resumes counting from the held value.
- R8: Timer enable disconnects the flag, so `irq_lvl` follows the square wave even while the flag is set.
- R9: While `sys_en` is 0, neither the prescaler nor the divider advances.
- R10: Command priority is watchdog disable, then watchdog enable, then timer disable, then timer enable. Timer disable acts only in TBASE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_en | input | 1 | System running; low freezes all counting |
| presc_bypass | input | 1 | 1: clock is already the 32 kHz base |
| rate_sel | input | RATE_W | Output rate exponent n |
| tmr_en_cmd | input | 1 | Strobe: route time base |
| tmr_dis_cmd | input | 1 | Strobe: stop time-base routing |
| wdt_en_cmd | input | 1 | Strobe: run and route watchdog |
| wdt_dis_cmd | input | 1 | Strobe: halt divider |
| irq_en_cmd | input | 1 | Strobe: drive interrupt pin |
| irq_dis_cmd | input | 1 | Strobe: float pin, drop flag |
| clr_tmr_cmd | input | 1 | Strobe: clear divider |
| clr_wdt_cmd | input | 1 | Strobe: clear divider and watchdog |
| irq_oe | output | 1 | Pin driven when 1 |
| irq_lvl | output | 1 | Pin level when driven |

## Verification
Two events can collide in one cycle: a clear-watchdog strobe, and the divider edge that completes the fourth period and would set the flag. The bench times the strobe so that it lands on exactly that edge. It then expects the flag to stay low and a full new four-period window to pass before the line drops. A second collision pairs IRQ enable with IRQ disable, and the routing strobes with each other, and the bench reads the pin to see which command won.

// File: rtl/tbwd_pkg.sv
package tbwd_pkg;
    typedef enum logic [1:0] {
        RT_HALT  = 2'd0,
        RT_TBASE = 2'd1,
        RT_WDOG  = 2'd2
    } route_t;
endpackage

// File: rtl/tbwd_prescaler.sv
module tbwd_prescaler #(
    parameter int PRE_LOG2 = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_en,
    input  logic bypass,
    input  logic clr,
    output logic tick
);
    generate
        if (PRE_LOG2 == 0) begin : g_direct
            assign tick = sys_en;
        end else begin : g_divide
            logic [PRE_LOG2-1:0] pre_cnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    pre_cnt <= '0;
                else if (clr)
                    pre_cnt <= '0;
                else if (sys_en && !bypass)
                    pre_cnt <= pre_cnt + PRE_LOG2'(1);
            end
            assign tick = sys_en && (bypass || (&pre_cnt));
        end
    endgenerate
endmodule

// File: rtl/tbwd_divider.sv
module tbwd_divider #(
    parameter int TB_STAGES = 15,
    parameter int RATE_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 run,
    input  logic                 clr,
    input  logic [RATE_W-1:0]    rate_sel,
    output logic [TB_STAGES-1:0] cnt,
    output logic                 sq,
    output logic                 period_end
);
    localparam int IDX_W = $clog2(TB_STAGES);

    logic [IDX_W-1:0]     sel_idx;
    logic [TB_STAGES-1:0] cnt_nxt;
    logic                 adv;

    assign sel_idx = IDX_W'(TB_STAGES - 1) - IDX_W'(rate_sel);
    assign cnt_nxt = cnt + TB_STAGES'(1);
    assign adv     = run && tick && !clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (adv)
            cnt <= cnt_nxt;
    end

    assign sq         = cnt[sel_idx];
    assign period_end = adv && cnt[sel_idx] && !cnt_nxt[sel_idx];
endmodule

// File: rtl/tbwd_watchdog.sv
module tbwd_watchdog #(
    parameter int WD_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic clr,
    input  logic drop_flag,
    output logic flag
);
    logic [WD_STAGES-1:0] wd_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_cnt <= '0;
            flag   <= 1'b0;
        end else if (clr) begin
            wd_cnt <= '0;
            flag   <= 1'b0;
        end else begin
            if (step) begin
                wd_cnt <= wd_cnt + WD_STAGES'(1);
                if (&wd_cnt)
                    flag <= 1'b1;
            end
            if (drop_flag)
                flag <= 1'b0;
        end
    end
endmodule

// File: rtl/tbwd_route_fsm.sv
module tbwd_route_fsm
    import tbwd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tmr_en,
    input  logic   tmr_dis,
    input  logic   wdt_en,
    input  logic   wdt_dis,
    input  logic   irq_en,
    input  logic   irq_dis,
    input  logic   sq,
    input  logic   wd_flag,
    output route_t state,
    output logic   irq_oe,
    output logic   irq_lvl
);
    route_t state_nxt;
    logic   irq_on;

    always_comb begin
        state_nxt = state;
        if (wdt_dis)
            state_nxt = RT_HALT;
        else if (wdt_en)
            state_nxt = RT_WDOG;
        else begin
            unique case (state)
                RT_HALT:  if (tmr_en && !tmr_dis) state_nxt = RT_TBASE;
                RT_TBASE: if (tmr_dis)            state_nxt = RT_HALT;
                RT_WDOG:  if (tmr_en)             state_nxt = RT_TBASE;
                default:                          state_nxt = RT_HALT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= RT_HALT;
            irq_on <= 1'b0;
        end else begin
            state <= state_nxt;
            if (irq_dis)
                irq_on <= 1'b0;
            else if (irq_en)
                irq_on <= 1'b1;
        end
    end

    always_comb begin
        irq_oe = irq_on;
        unique case (state)
            RT_TBASE: irq_lvl = sq;
            RT_WDOG:  irq_lvl = !wd_flag;
            default:  irq_lvl = 1'b1;
        endcase
    end
endmodule

// File: rtl/tbwd_irq.sv
module tbwd_irq
    import tbwd_pkg::*;
#(
    parameter int TB_STAGES = 15,
    parameter int PRE_LOG2  = 3,
    parameter int RATE_W    = 3,
    parameter int WD_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_en,
    input  logic              presc_bypass,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              tmr_en_cmd,
    input  logic              tmr_dis_cmd,
    input  logic              wdt_en_cmd,
    input  logic              wdt_dis_cmd,
    input  logic              irq_en_cmd,
    input  logic              irq_dis_cmd,
    input  logic              clr_tmr_cmd,
    input  logic              clr_wdt_cmd,
    output logic              irq_oe,
    output logic              irq_lvl
);
    logic                 base_tick;
    logic                 tb_clr;
    logic                 cnt_run;
    logic [TB_STAGES-1:0] tb_cnt;
    logic                 tb_sq;
    logic                 tb_period_end;
    logic                 wd_flag;
    route_t               route_st;

    assign tb_clr  = clr_tmr_cmd || clr_wdt_cmd;
    assign cnt_run = (route_st != RT_HALT);

    tbwd_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .sys_en (sys_en),
        .bypass (presc_bypass),
        .clr    (tb_clr),
        .tick   (base_tick)
    );

    tbwd_divider #(.TB_STAGES(TB_STAGES), .RATE_W(RATE_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (base_tick),
        .run        (cnt_run),
        .clr        (tb_clr),
        .rate_sel   (rate_sel),
        .cnt        (tb_cnt),
        .sq         (tb_sq),
        .period_end (tb_period_end)
    );

    tbwd_watchdog #(.WD_STAGES(WD_STAGES)) u_wd (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (tb_period_end && (route_st == RT_WDOG)),
        .clr       (clr_wdt_cmd),
        .drop_flag (irq_dis_cmd),
        .flag      (wd_flag)
    );

    tbwd_route_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tmr_en  (tmr_en_cmd),
        .tmr_dis (tmr_dis_cmd),
        .wdt_en  (wdt_en_cmd),
        .wdt_dis (wdt_dis_cmd),
        .irq_en  (irq_en_cmd),
        .irq_dis (irq_dis_cmd),
        .sq      (tb_sq),
        .wd_flag (wd_flag),
        .state   (route_st),
        .irq_oe  (irq_oe),
        .irq_lvl (irq_lvl)
    );
endmodule

// File: rtl/tbwd_irq_chk.sv
module tbwd_irq_chk
    import tbwd_pkg::*;
#(
    parameter int TB_STAGES = 15
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sys_en,
    input logic                 base_tick,
    input logic                 cnt_run,
    input logic                 tb_clr,
    input logic                 clr_wdt_cmd,
    input logic                 irq_en_cmd,
    input logic                 irq_dis_cmd,
    input logic                 wdt_dis_cmd,
    input route_t               route_st,
    input logic [TB_STAGES-1:0] tb_cnt,
    input logic                 wd_flag,
    input logic                 irq_oe
);
    AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        irq_dis_cmd |=> !irq_oe); // R2
    AST_IRQ_ON: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en_cmd && !irq_dis_cmd |=> irq_oe); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_run && base_tick && !tb_clr |=> tb_cnt == TB_STAGES'($past(tb_cnt) + 1'b1)); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wd_flag && !clr_wdt_cmd && !irq_dis_cmd |=> wd_flag); // R5
    AST_CLR_WDT: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wdt_cmd |=> (tb_cnt == '0) && !wd_flag); // R6
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (route_st == RT_HALT) && !tb_clr |=> $stable(tb_cnt)); // R7
    AST_SYS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_en && !tb_clr |=> $stable(tb_cnt)); // R9
    AST_WDIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_dis_cmd |=> route_st == RT_HALT); // R10
endmodule

bind tbwd_irq tbwd_irq_chk #(.TB_STAGES(TB_STAGES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_en      (sys_en),
    .base_tick   (base_tick),
    .cnt_run     (cnt_run),
    .tb_clr      (tb_clr),
    .clr_wdt_cmd (clr_wdt_cmd),
    .irq_en_cmd  (irq_en_cmd),
    .irq_dis_cmd (irq_dis_cmd),
    .wdt_dis_cmd (wdt_dis_cmd),
    .route_st    (route_st),
    .tb_cnt      (tb_cnt),
    .wd_flag     (wd_flag),
    .irq_oe      (irq_oe)
);

// File: tb/tb_tbwd_irq.sv
`timescale 1ns/1ps
module tb_tbwd_irq;
    localparam int STG = 10;
    localparam logic [7:0] M_TE = 8'h01, M_TD = 8'h02, M_WE = 8'h04, M_WD = 8'h08,
                           M_IE = 8'h10, M_ID = 8'h20, M_CT = 8'h40, M_CW = 8'h80;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sys_en = 1'b1;
    logic       presc_bypass = 1'b1;
    logic [2:0] rate_sel = 3'd7;
    logic [7:0] cmd_v = 8'h00;
    logic       irq_oe, irq_lvl;
    int         n_chk = 0;
    int         n_fail = 0;

    always #2.5 clk = ~clk;

    tbwd_irq #(.TB_STAGES(STG), .PRE_LOG2(3), .RATE_W(3), .WD_STAGES(2)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sys_en       (sys_en),
        .presc_bypass (presc_bypass),
        .rate_sel     (rate_sel),
        .tmr_en_cmd   (cmd_v[0]),
        .tmr_dis_cmd  (cmd_v[1]),
        .wdt_en_cmd   (cmd_v[2]),
        .wdt_dis_cmd  (cmd_v[3]),
        .irq_en_cmd   (cmd_v[4]),
        .irq_dis_cmd  (cmd_v[5]),
        .clr_tmr_cmd  (cmd_v[6]),
        .clr_wdt_cmd  (cmd_v[7]),
        .irq_oe       (irq_oe),
        .irq_lvl      (irq_lvl)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] m);
        @(negedge clk);
        cmd_v = m;
        @(negedge clk);
        cmd_v = 8'h00;
    endtask

    task automatic t_reset;
        chk(irq_oe, 1'b0, "R1 oe after reset");
        chk(irq_lvl, 1'b1, "R1 lvl after reset");
        wait_n(20);
        chk(irq_oe, 1'b0, "R1 oe idle");
    endtask

    task automatic t_timer;
        rate_sel = 3'd7;
        cmd(M_TE | M_CT | M_IE);
        chk(irq_oe, 1'b1, "R2 oe enabled");
        wait_n(1); chk(irq_lvl, 1'b0, "R3 k1 low");
        wait_n(2); chk(irq_lvl, 1'b0, "R3 k3 low");
        wait_n(1); chk(irq_lvl, 1'b1, "R3 k4 high");
        wait_n(3); chk(irq_lvl, 1'b1, "R3 k7 high");
        wait_n(1); chk(irq_lvl, 1'b0, "R3 k8 low");
    endtask

    task automatic t_rate;
        rate_sel = 3'd5;
        cmd(M_CT);
        wait_n(15); chk(irq_lvl, 1'b0, "R3 sel5 k15");
        wait_n(1);  chk(irq_lvl, 1'b1, "R3 sel5 k16");
        wait_n(16); chk(irq_lvl, 1'b0, "R3 sel5 k32");
        rate_sel = 3'd7;
    endtask

    task automatic t_presc;
        presc_bypass = 1'b0;
        cmd(M_CT);
        wait_n(31); chk(irq_lvl, 1'b0, "R4 prescaled k31");
        wait_n(1);  chk(irq_lvl, 1'b1, "R4 prescaled k32");
        presc_bypass = 1'b1;
    endtask

    task automatic t_wdog;
        cmd(M_WE | M_CW | M_IE);
        wait_n(31); chk(irq_lvl, 1'b1, "R5 before timeout");
        wait_n(1);  chk(irq_lvl, 1'b0, "R5 timeout");
        wait_n(68); chk(irq_lvl, 1'b0, "R5 held low");
        cmd(M_CT);  chk(irq_lvl, 1'b0, "R6 clr timer keeps flag");
        cmd(M_CW);  chk(irq_lvl, 1'b1, "R6 clr wdt drops flag");
    endtask

    task automatic t_irqdis;
        wait_n(32); chk(irq_lvl, 1'b0, "R5 second timeout");
        cmd(M_ID);  chk(irq_oe, 1'b0, "R2 disable floats");
        cmd(M_IE);  chk(irq_oe, 1'b1, "R2 reenable");
        chk(irq_lvl, 1'b1, "R2 disable dropped flag");
        cmd(M_IE | M_ID); chk(irq_oe, 1'b0, "R2 disable wins");
        cmd(M_IE);
    endtask

    task automatic t_tmr_over_wdt;
        cmd(M_CW);
        wait_n(32); chk(irq_lvl, 1'b0, "R8 flag set");
        cmd(M_TE | M_CT);
        wait_n(4);  chk(irq_lvl, 1'b1, "R8 wave not flag");
    endtask

    task automatic t_halt;
        cmd(M_TE | M_CT);
        wait_n(5);
        cmd(M_WD);  chk(irq_lvl, 1'b1, "R7 halt releases");
        wait_n(40); chk(irq_lvl, 1'b1, "R7 halt stays");
        cmd(M_TE);  chk(irq_lvl, 1'b1, "R7 resumed at 7");
        wait_n(1);  chk(irq_lvl, 1'b0, "R7 resumed at 8");
    endtask

    task automatic t_sys;
        cmd(M_CT);
        wait_n(4);  chk(irq_lvl, 1'b1, "R9 count4");
        sys_en = 1'b0;
        wait_n(20); chk(irq_lvl, 1'b1, "R9 frozen");
        sys_en = 1'b1;
        wait_n(3);  chk(irq_lvl, 1'b1, "R9 count7");
        wait_n(1);  chk(irq_lvl, 1'b0, "R9 count8");
    endtask

    task automatic t_same_cycle;
        cmd(M_WE | M_CW);
        wait_n(30);
        cmd(M_CW);  chk(irq_lvl, 1'b1, "R6 clear beats timeout");
        wait_n(31); chk(irq_lvl, 1'b1, "R6 fresh window");
        wait_n(1);  chk(irq_lvl, 1'b0, "R5 timeout after clear");
    endtask

    task automatic t_prio;
        cmd(M_TE | M_CT);
        chk(irq_lvl, 1'b0, "R10 tbase low");
        cmd(M_WD | M_TE | M_CT); chk(irq_lvl, 1'b1, "R10 wdt dis beats tmr en");
        cmd(M_WE | M_TE | M_CW); chk(irq_lvl, 1'b1, "R10 wdt en beats tmr en");
        wait_n(32); chk(irq_lvl, 1'b0, "R10 in wdog");
        cmd(M_TE | M_CT); chk(irq_lvl, 1'b0, "R10 back to tbase");
        cmd(M_TD);  chk(irq_lvl, 1'b1, "R10 tmr dis halts");
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        t_reset();
        t_timer();
        t_rate();
        t_presc();
        t_wdog();
        t_irqdis();
        t_tmr_over_wdt();
        t_halt();
        t_sys();
        t_same_cycle();
        t_prio();
        wait_n(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule